// File: doc/BRIEF.md
# Machine CSR Access and Environment-Call Trap Unit

This block keeps three machine-level control and status registers (trap vector base, exception PC and trap cause) and carries out the six atomic CSR read-modify-write instructions and the environment-call instruction. The core's decode stage provides the opcode, the funct3 field, the 12-bit CSR address, the rs1 index field and the rs1 register value. It also provides a valid strobe, the current privilege level and the PC of the instruction. The 5-bit immediate forms take their operand from the rs1 index field.

For a CSR instruction, the old register value appears on `rd_val` in the same cycle. The updated value is written at the next rising clock edge. For an environment call, `trap` is raised and `trap_pc` gives the trap vector in the same cycle. At the next edge the cause and exception-PC registers are loaded. Every other CSR address reads as zero and ignores writes.

Top module: `csr_trap_unit`

## Requirements
- R1: A synchronous active-high reset clears the trap vector (address 0x305), the exception PC (0x341) and the cause register (0x342) to zero.
- R2: A valid CSR instruction drives the register's value from before the instruction onto `rd_val` in the same cycle. The new value becomes visible from the next rising edge onward.
- R3: funct3 001 (register operand) and 101 (immediate operand) replace the CSR with the operand.
- R4: funct3 010 (register) and 110 (immediate) OR the operand into the CSR.
- R5: funct3 011 (register) and 111 (immediate) AND the CSR with the inverted operand.
- R6: The immediate forms (funct3 bit 2 set) use the 5-bit rs1 index field, zero-extended, as the operand, and `rs1_val` has no effect.
- R7: A set or clear form whose rs1 index field is 0 leaves the CSR unchanged but still returns its old value. A write form with index 0 still writes.
- R8: A CSR instruction to any address other than 0x305, 0x341 or 0x342 returns zero and changes no register.
- R9: An environment call is a valid instruction with opcode 1110011, funct3 000, CSR address field 0 and rs1 index 0. In that cycle it raises `trap`, drives `trap_pc` with the trap vector and drives `rd_val` with zero. At the next edge the cause register takes 8 plus `priv` (0 user, 1 supervisor, 2 hypervisor, 3 machine) and the exception PC takes `pc`.
- R10: While `valid` is low, `trap` and `rd_val` are 0, `trap_pc` is 0, and no register changes.
- R11: An instruction whose opcode is not 1110011, one with funct3 100, and one with funct3 000 that has a nonzero address or rs1 index field returns zero, raises no trap and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Instruction fields are valid this cycle |
| opcode | input | 7 | Instruction opcode field |
| funct3 | input | 3 | Operation select field |
| csr_addr | input | 12 | CSR address field (bits 31:20) |
| rs1_idx | input | 5 | rs1 index field, also the 5-bit immediate |
| rs1_val | input | 32 | Value of register rs1 |
| priv | input | 2 | Current privilege level |
| pc | input | 32 | PC of the instruction |
| rd_val | output | 32 | Old CSR value for the destination register |
| trap | output | 1 | Environment-call trap taken |
| trap_pc | output | 32 | Next PC on a trap (trap vector) |

## Verification
The assertions assume that `rst` is held for at least one edge before the first instruction. They also assume that reset does not rise in the cycle just after an environment call, because the cause and exception-PC checks look one edge ahead of the trap. The bench keeps to these assumptions: it asserts reset from time zero and changes inputs only on falling edges. When `valid` is low, it drives random-looking junk on the other inputs, so the checks for ignored cycles test a real condition. It also places accesses to unimplemented addresses and index-0 set/clear operations between reads, so that every register is still observed through the normal read path.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

   localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_SET   = 2'd2,
      OP_CLEAR = 2'd3
   } csr_op_e;

   typedef struct packed {
      logic    csr_en;
      logic    ecall;
      csr_op_e op;
      logic    use_imm;
      logic    no_write;
   } csr_cmd_t;

   // register slot roles inside the bank
   localparam int SLOT_TVEC  = 0;
   localparam int SLOT_EPC   = 1;
   localparam int SLOT_CAUSE = 2;
   localparam int NUM_SLOTS  = 3;

   function automatic logic [3:0] ecall_code(input logic [1:0] p);
      return {2'b10, p};
   endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
   import csr_trap_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 5
) (
   input  logic              valid,
   input  logic [6:0]        opcode,
   input  logic [2:0]        funct3,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [IDX_W-1:0]  rs1_idx,
   output csr_cmd_t          cmd
);

   logic is_sys;
   logic idx_zero;

   assign is_sys   = valid && (opcode == OPC_SYSTEM);
   assign idx_zero = (rs1_idx == '0);

   always_comb begin
      cmd = '0;
      if (is_sys) begin
         unique case (funct3)
            3'b000: cmd.ecall = (csr_addr == '0) && idx_zero;
            3'b001, 3'b101: begin
               cmd.csr_en = 1'b1;
               cmd.op     = OP_WRITE;
            end
            3'b010, 3'b110: begin
               cmd.csr_en = 1'b1;
               cmd.op     = OP_SET;
            end
            3'b011, 3'b111: begin
               cmd.csr_en = 1'b1;
               cmd.op     = OP_CLEAR;
            end
            default: cmd = '0;
         endcase
         cmd.use_imm  = funct3[2];
         cmd.no_write = (funct3[1:0] != 2'b01) && idx_zero;
      end
   end

endmodule

// File: rtl/csr_alu.sv
module csr_alu
   import csr_trap_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
) (
   input  csr_cmd_t         cmd,
   input  logic [XLEN-1:0]  old_val,
   input  logic [XLEN-1:0]  rs1_val,
   input  logic [IDX_W-1:0] rs1_idx,
   output logic [XLEN-1:0]  new_val,
   output logic             wr_en
);

   localparam int PAD_W = XLEN - IDX_W;

   logic [XLEN-1:0] operand;

   assign operand = cmd.use_imm ? {{PAD_W{1'b0}}, rs1_idx} : rs1_val;

   always_comb begin
      unique case (cmd.op)
         OP_WRITE: new_val = operand;
         OP_SET:   new_val = old_val | operand;
         OP_CLEAR: new_val = old_val & ~operand;
         default:  new_val = old_val;
      endcase
   end

   assign wr_en = cmd.csr_en && !cmd.no_write;

endmodule

// File: rtl/csr_bank.sv
module csr_bank
   import csr_trap_pkg::*;
#(
   parameter int                XLEN       = 32,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] ADDR_TVEC  = 12'h305,
   parameter logic [ADDR_W-1:0] ADDR_EPC   = 12'h341,
   parameter logic [ADDR_W-1:0] ADDR_CAUSE = 12'h342
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [XLEN-1:0]   wr_data,
   input  logic              trap_ld,
   input  logic [XLEN-1:0]   cause_in,
   input  logic [XLEN-1:0]   epc_in,
   output logic [XLEN-1:0]   rd_data,
   output logic [XLEN-1:0]   tvec_q,
   output logic [XLEN-1:0]   epc_q,
   output logic [XLEN-1:0]   cause_q
);

   logic [NUM_SLOTS-1:0]           hit;
   logic [NUM_SLOTS-1:0][XLEN-1:0] qv;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] MY_ADDR =
         (i == SLOT_TVEC) ? ADDR_TVEC :
         (i == SLOT_EPC)  ? ADDR_EPC  : ADDR_CAUSE;

      logic [XLEN-1:0] q_r;
      logic [XLEN-1:0] trap_val;

      if (i == SLOT_EPC) begin : g_epc
         assign trap_val = epc_in;
      end else if (i == SLOT_CAUSE) begin : g_cause
         assign trap_val = cause_in;
      end else begin : g_keep
         assign trap_val = q_r;
      end

      assign hit[i] = (addr == MY_ADDR);

      always_ff @(posedge clk) begin
         if (rst)
            q_r <= '0;
         else if (trap_ld)
            q_r <= trap_val;
         else if (wr_en && hit[i])
            q_r <= wr_data;
      end

      assign qv[i] = q_r;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_SLOTS; k++)
         if (hit[k]) rd_data = rd_data | qv[k];
   end

   assign tvec_q  = qv[SLOT_TVEC];
   assign epc_q   = qv[SLOT_EPC];
   assign cause_q = qv[SLOT_CAUSE];

endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
   import csr_trap_pkg::*;
#(
   parameter int                XLEN       = 32,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] ADDR_TVEC  = 12'h305,
   parameter logic [ADDR_W-1:0] ADDR_EPC   = 12'h341,
   parameter logic [ADDR_W-1:0] ADDR_CAUSE = 12'h342
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid,
   input  logic [6:0]        opcode,
   input  logic [2:0]        funct3,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [4:0]        rs1_idx,
   input  logic [XLEN-1:0]   rs1_val,
   input  logic [1:0]        priv,
   input  logic [XLEN-1:0]   pc,
   output logic [XLEN-1:0]   rd_val,
   output logic              trap,
   output logic [XLEN-1:0]   trap_pc
);

   localparam int IDX_W   = 5;
   localparam int CODE_W  = 4;
   localparam int CPAD_W  = XLEN - CODE_W;

   if (XLEN < 8) begin : g_bad_xlen
      $error("csr_trap_unit: XLEN must be at least 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("csr_trap_unit: ADDR_W too small");
   end
   if (ADDR_TVEC == ADDR_EPC || ADDR_TVEC == ADDR_CAUSE || ADDR_EPC == ADDR_CAUSE) begin : g_dup_addr
      $error("csr_trap_unit: CSR addresses must be distinct");
   end
   if (ADDR_TVEC == '0 || ADDR_EPC == '0 || ADDR_CAUSE == '0) begin : g_zero_addr
      $error("csr_trap_unit: address 0 is reserved for the call encoding");
   end

   csr_cmd_t        cmd;
   logic [XLEN-1:0] old_val;
   logic [XLEN-1:0] new_val;
   logic            wr_en;
   logic [XLEN-1:0] cause_in;
   logic [XLEN-1:0] tvec_q;
   logic [XLEN-1:0] epc_q;
   logic [XLEN-1:0] cause_q;

   csr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .valid    (valid),
      .opcode   (opcode),
      .funct3   (funct3),
      .csr_addr (csr_addr),
      .rs1_idx  (rs1_idx),
      .cmd      (cmd)
   );

   csr_alu #(.XLEN(XLEN), .IDX_W(IDX_W)) u_alu (
      .cmd     (cmd),
      .old_val (old_val),
      .rs1_val (rs1_val),
      .rs1_idx (rs1_idx),
      .new_val (new_val),
      .wr_en   (wr_en)
   );

   assign cause_in = {{CPAD_W{1'b0}}, ecall_code(priv)};

   csr_bank #(
      .XLEN       (XLEN),
      .ADDR_W     (ADDR_W),
      .ADDR_TVEC  (ADDR_TVEC),
      .ADDR_EPC   (ADDR_EPC),
      .ADDR_CAUSE (ADDR_CAUSE)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .addr     (csr_addr),
      .wr_en    (wr_en),
      .wr_data  (new_val),
      .trap_ld  (cmd.ecall),
      .cause_in (cause_in),
      .epc_in   (pc),
      .rd_data  (old_val),
      .tvec_q   (tvec_q),
      .epc_q    (epc_q),
      .cause_q  (cause_q)
   );

   assign rd_val  = cmd.csr_en ? old_val : '0;
   assign trap    = cmd.ecall;
   assign trap_pc = cmd.ecall ? tvec_q : '0;

endmodule

// File: rtl/csr_trap_chk.sv
module csr_trap_chk
   import csr_trap_pkg::*;
#(
   parameter int                XLEN       = 32,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] ADDR_TVEC  = 12'h305,
   parameter logic [ADDR_W-1:0] ADDR_EPC   = 12'h341,
   parameter logic [ADDR_W-1:0] ADDR_CAUSE = 12'h342
) (
   input logic              clk,
   input logic              rst,
   input logic              valid,
   input logic [6:0]        opcode,
   input logic [2:0]        funct3,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [4:0]        rs1_idx,
   input logic [1:0]        priv,
   input logic [XLEN-1:0]   pc,
   input logic [XLEN-1:0]   rd_val,
   input logic              trap,
   input logic [XLEN-1:0]   tvec_q,
   input logic [XLEN-1:0]   epc_q,
   input logic [XLEN-1:0]   cause_q
);

   logic unimpl;
   logic sys_rmw;
   assign unimpl  = (csr_addr != ADDR_TVEC) && (csr_addr != ADDR_EPC) && (csr_addr != ADDR_CAUSE);
   assign sys_rmw = valid && (opcode == OPC_SYSTEM);

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (tvec_q == '0) && (epc_q == '0) && (cause_q == '0));

   assert_quiet_no_change_R10: assert property (@(posedge clk) disable iff (rst)
      !valid |=> $stable(tvec_q) && $stable(epc_q) && $stable(cause_q));

   assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (rst)
      !valid |-> !trap && (rd_val == '0));

   assert_x0_keeps_R7: assert property (@(posedge clk) disable iff (rst)
      sys_rmw && (funct3[1] == 1'b1) && (rs1_idx == '0)
      |=> $stable(tvec_q) && $stable(epc_q) && $stable(cause_q));

   assert_unimpl_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
      valid && unimpl && !trap |-> (rd_val == '0));

   assert_unimpl_no_write_R8: assert property (@(posedge clk) disable iff (rst)
      valid && unimpl && !trap |=> $stable(tvec_q) && $stable(epc_q) && $stable(cause_q));

   assert_call_cause_R9: assert property (@(posedge clk) disable iff (rst)
      trap |=> (cause_q == {{(XLEN-4){1'b0}}, 2'b10, $past(priv)}) && (epc_q == $past(pc)));

   assert_call_keeps_tvec_R9: assert property (@(posedge clk) disable iff (rst)
      trap |=> $stable(tvec_q));

endmodule

bind csr_trap_unit csr_trap_chk #(
   .XLEN       (XLEN),
   .ADDR_W     (ADDR_W),
   .ADDR_TVEC  (ADDR_TVEC),
   .ADDR_EPC   (ADDR_EPC),
   .ADDR_CAUSE (ADDR_CAUSE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .valid    (valid),
   .opcode   (opcode),
   .funct3   (funct3),
   .csr_addr (csr_addr),
   .rs1_idx  (rs1_idx),
   .priv     (priv),
   .pc       (pc),
   .rd_val   (rd_val),
   .trap     (trap),
   .tvec_q   (tvec_q),
   .epc_q    (epc_q),
   .cause_q  (cause_q)
);

// File: tb/sim_csr_trap_unit.sv
module sim_csr_trap_unit;

   localparam logic [6:0]  SYS   = 7'b1110011;
   localparam logic [11:0] A_TV  = 12'h305;
   localparam logic [11:0] A_EP  = 12'h341;
   localparam logic [11:0] A_CA  = 12'h342;

   typedef struct {
      logic [31:0] rd;
      logic        trp;
      logic [31:0] tpc;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid = 1'b0;
   logic [6:0]  opcode = '0;
   logic [2:0]  funct3 = '0;
   logic [11:0] csr_addr = '0;
   logic [4:0]  rs1_idx = '0;
   logic [31:0] rs1_val = '0;
   logic [1:0]  priv = '0;
   logic [31:0] pc = '0;
   logic [31:0] rd_val;
   logic        trap;
   logic [31:0] trap_pc;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   logic [31:0] m_tv = '0, m_ep = '0, m_ca = '0;

   always #5 clk = ~clk;

   csr_trap_unit u0 (
      .clk(clk), .rst(rst), .valid(valid), .opcode(opcode), .funct3(funct3),
      .csr_addr(csr_addr), .rs1_idx(rs1_idx), .rs1_val(rs1_val), .priv(priv),
      .pc(pc), .rd_val(rd_val), .trap(trap), .trap_pc(trap_pc)
   );

   task automatic issue(input logic [6:0] opc, input logic [2:0] f3, input logic [11:0] a,
                        input logic [4:0] idx, input logic [31:0] v, input logic [1:0] p,
                        input logic [31:0] pcv, input string tag);
      exp_t e;
      logic [31:0] old, opnd, nv;
      bit hit;
      @(negedge clk);
      valid = 1'b1; opcode = opc; funct3 = f3; csr_addr = a;
      rs1_idx = idx; rs1_val = v; priv = p; pc = pcv;
      e.rd = '0; e.trp = 1'b0; e.tpc = '0; e.tag = tag;
      if (opc == SYS && f3 == 3'b000 && a == '0 && idx == '0) begin
         e.trp = 1'b1; e.tpc = m_tv;
         m_ca = 32'd8 + {30'd0, p};
         m_ep = pcv;
      end else if (opc == SYS && f3[1:0] != 2'b00) begin
         hit = 1;
         if (a == A_TV) old = m_tv;
         else if (a == A_EP) old = m_ep;
         else if (a == A_CA) old = m_ca;
         else begin old = '0; hit = 0; end
         e.rd = old;
         opnd = f3[2] ? {27'd0, idx} : v;
         if (f3[1:0] == 2'b01) nv = opnd;
         else if (f3[1:0] == 2'b10) nv = old | opnd;
         else nv = old & ~opnd;
         if (hit && !(f3[1:0] != 2'b01 && idx == '0)) begin
            if (a == A_TV) m_tv = nv;
            else if (a == A_EP) m_ep = nv;
            else m_ca = nv;
         end
      end
      q.push_back(e);
   endtask

   task automatic idle(input string tag);
      exp_t e;
      @(negedge clk);
      valid = 1'b0; opcode = SYS; funct3 = 3'b001; csr_addr = A_TV;
      rs1_idx = 5'h1F; rs1_val = 32'hDEAD_BEEF; priv = 2'd3; pc = 32'h1234_5678;
      e.rd = '0; e.trp = 1'b0; e.tpc = '0; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic rd_csr(input logic [11:0] a, input string tag);
      issue(SYS, 3'b010, a, 5'd0, 32'hFFFF_FFFF, 2'd0, 32'h0, tag);
   endtask

   // monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #3;
         if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (rd_val !== e.rd || trap !== e.trp || trap_pc !== e.tpc) begin
               errors++;
               $display("FAIL %s: actual rd=%h trap=%b tpc=%h expected rd=%h trap=%b tpc=%h",
                        e.tag, rd_val, trap, trap_pc, e.rd, e.trp, e.tpc);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      rd_csr(A_TV, "R1 tvec after reset");
      rd_csr(A_EP, "R1 epc after reset");
      rd_csr(A_CA, "R1 cause after reset");
      issue(SYS, 3'b001, A_TV, 5'd5, 32'h8000_0100, 2'd3, 0, "R3 write reg");
      rd_csr(A_TV, "R2 new value visible");
      issue(SYS, 3'b010, A_TV, 5'd3, 32'h0000_000C, 2'd3, 0, "R4 set reg");
      issue(SYS, 3'b011, A_TV, 5'd4, 32'h0000_0004, 2'd3, 0, "R5 clear reg");
      rd_csr(A_TV, "R2 R5 result");
      issue(SYS, 3'b101, A_EP, 5'h1F, 32'hFFFF_FFFF, 2'd3, 0, "R6 write imm ignores rs1_val");
      issue(SYS, 3'b110, A_CA, 5'd5, 32'hFFFF_0000, 2'd3, 0, "R4 R6 set imm");
      issue(SYS, 3'b111, A_CA, 5'd1, 32'h0000_0004, 2'd3, 0, "R5 R6 clear imm");
      rd_csr(A_EP, "R6 epc readback");
      rd_csr(A_CA, "R5 cause readback");
      issue(SYS, 3'b011, A_TV, 5'd0, 32'hFFFF_FFFF, 2'd3, 0, "R7 clear x0");
      issue(SYS, 3'b111, A_CA, 5'd0, 32'hFFFF_FFFF, 2'd3, 0, "R7 clear imm zero");
      issue(SYS, 3'b110, A_EP, 5'd0, 32'hFFFF_FFFF, 2'd3, 0, "R7 set imm zero");
      rd_csr(A_TV, "R7 tvec kept");
      rd_csr(A_CA, "R7 cause kept");
      issue(SYS, 3'b001, A_EP, 5'd0, 32'h0, 2'd3, 0, "R7 write x0 writes");
      rd_csr(A_EP, "R7 epc zeroed");
      issue(SYS, 3'b001, 12'h300, 5'd6, 32'hA5A5_A5A5, 2'd3, 0, "R8 unimpl write");
      issue(SYS, 3'b010, 12'h300, 5'd0, 32'h0, 2'd3, 0, "R8 unimpl read");
      issue(SYS, 3'b111, 12'h306, 5'h1F, 32'h0, 2'd3, 0, "R8 unimpl clear");
      rd_csr(A_TV, "R8 tvec untouched");
      rd_csr(A_CA, "R8 cause untouched");
      for (int p = 0; p < 4; p++) begin
         issue(SYS, 3'b000, 12'h000, 5'd0, 32'hFFFF_FFFF, p[1:0], 32'h0000_2000 + 32'(p * 4), "R9 ecall");
         rd_csr(A_CA, "R9 cause value");
         rd_csr(A_EP, "R9 epc value");
      end
      issue(SYS, 3'b000, 12'h000, 5'd0, 32'h0, 2'd1, 32'h0000_3000, "R9 back-to-back ecall");
      issue(SYS, 3'b000, 12'h000, 5'd0, 32'h0, 2'd2, 32'h0000_3004, "R9 back-to-back ecall");
      rd_csr(A_CA, "R9 cause after pair");
      rd_csr(A_EP, "R9 epc after pair");
      idle("R10 idle 1");
      idle("R10 idle 2");
      rd_csr(A_TV, "R10 tvec kept");
      issue(7'b0110011, 3'b001, A_TV, 5'd2, 32'h0, 2'd3, 0, "R11 other opcode");
      issue(SYS, 3'b100, A_TV, 5'd2, 32'h0, 2'd3, 0, "R11 funct3 100");
      issue(SYS, 3'b000, 12'h001, 5'd0, 32'h0, 2'd3, 32'h4444, "R11 funct3 000 nonzero addr");
      issue(SYS, 3'b000, 12'h000, 5'd7, 32'h0, 2'd3, 32'h4444, "R11 funct3 000 nonzero idx");
      rd_csr(A_TV, "R11 tvec kept");
      rd_csr(A_EP, "R11 epc kept");
      rd_csr(A_CA, "R11 cause kept");
      idle("R10 final idle");
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule